// File: doc/BRIEF.md
# Branch Trace Packet Encoder

This block turns a core's stream of control-flow events into a compact byte stream that a decoder can later use to rebuild the executed path. A conditional branch costs one bit. Indirect branches carry their target address. Interrupts carry both the interrupted address and the handler address. An optional filter on the address-space root value keeps events from other processes out of the trace.

Output bytes leave through a valid/ready port. Each byte carries the write address it belongs to inside a programmed range. The range either works as a ring that wraps forever or as a linear buffer that stops and raises a flag once its last byte is written. The output back-pressures the event input. While bytes of a packet are still pending, no new event is taken.

Event kinds on `ev_kind` are 0 for a conditional branch, 1 for an indirect branch and 2 for an interrupt.

Top module: `bt_trace_enc`

## Requirements
- R1: After reset, `out_valid` and `trace_full` are 0, `ev_ready` is 1 and `out_addr` equals `cfg_base`.
- R2: Each accepted conditional branch adds one outcome bit (taken = 1). No byte is sent until six bits are held. The sixth bit produces one byte equal to 0xC0 OR the six bits, with the oldest bit in bit 5 and the newest in bit 0.
- R3: If n outcome bits (1 to 5) are pending when an address-bearing event is accepted, a flush byte 0x80 OR (1 << n) OR the n bits (oldest highest, newest in bit 0) is sent first.
- R4: An accepted indirect branch sends header 0x01 followed by the 8 target-address bytes, least significant byte first.
- R5: An accepted interrupt sends header 0x02, then the 8 source-address bytes, then the 8 destination-address bytes, each least significant byte first.
- R6: With `cfg_filter_en` set and `ev_root` different from `cfg_root_match`, the event adds no bits and sends no bytes, except that pending outcome bits are flushed as in R3. With the filter clear, all events are traced.
- R7: While `out_valid` is high and `out_ready` is low, `out_byte` and `out_addr` hold their values. `ev_ready` stays low while any byte of the previous packet is pending.
- R8: Successive bytes are written at consecutive addresses starting at `cfg_base`. With `cfg_ring` set, the byte after the one written at `cfg_last` goes to `cfg_base`.
- R9: With `cfg_ring` clear, once a byte is written at `cfg_last`, `trace_full` rises and stays high until reset, `out_valid` and `ev_ready` stay low, and no further byte is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event accepted on this cycle when valid |
| ev_kind | input | 2 | 0 conditional, 1 indirect, 2 interrupt |
| ev_taken | input | 1 | Conditional outcome |
| ev_src | input | IA_W | Interrupted address |
| ev_dst | input | IA_W | Branch or handler target |
| ev_root | input | ROOT_W | Current address-space root value |
| cfg_filter_en | input | 1 | Enable root filter |
| cfg_root_match | input | ROOT_W | Root value that is traced |
| cfg_ring | input | 1 | 1 ring, 0 stop when full |
| cfg_base | input | OA_W | First address of the range |
| cfg_last | input | OA_W | Last address of the range |
| out_valid | output | 1 | Byte available |
| out_ready | input | 1 | Sink takes the byte |
| out_addr | output | OA_W | Write address of the byte |
| out_byte | output | 8 | Trace byte |
| trace_full | output | 1 | Stop-mode range exhausted |

## Verification
The assertions assume that the range and mode inputs stay constant between resets, that `cfg_base` is not above `cfg_last`, and that `ev_kind` never takes the value 3. The stimulus sets the configuration only while reset is held. It issues only the three defined kinds. It changes event fields only at falling edges. The pointer, wrap and hold properties therefore see a fixed range.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {EV_COND = 2'd0, EV_IND = 2'd1, EV_INT = 2'd2} ev_kind_t;
  localparam logic [7:0] HDR_IND   = 8'h01;
  localparam logic [7:0] HDR_INT   = 8'h02;
  localparam logic [7:0] OUTC_MARK = 8'h80;
  localparam int         NBITS     = 6;
endpackage

// File: rtl/bt_pack.sv
module bt_pack
  import bt_pkg::*;
#(
  parameter int IA_W   = 64,
  parameter int ROOT_W = 48,
  parameter int MAXB   = 2 + 2 * (IA_W / 8),
  parameter int CW     = $clog2(MAXB + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic [1:0]          kind,
  input  logic                taken,
  input  logic [IA_W-1:0]     src,
  input  logic [IA_W-1:0]     dst,
  input  logic [ROOT_W-1:0]   root,
  input  logic                filt_en,
  input  logic [ROOT_W-1:0]   match,
  output logic                ld,
  output logic [MAXB*8-1:0]   ld_data,
  output logic [CW-1:0]       ld_cnt
);
  localparam int PW   = (MAXB - 1) * 8;
  localparam int CNTW = $clog2(NBITS + 1);

  logic [NBITS-1:0] acc, nacc;
  logic [CNTW-1:0]  cnt, ncnt;
  logic [PW-1:0]    pay;
  logic [CW-1:0]    pn;
  logic             hit, have;
  logic [7:0]       flush;

  assign hit   = !filt_en || (root == match);
  assign have  = (cnt != '0);
  assign flush = OUTC_MARK | (8'(1) << cnt) | 8'(acc);

  always_comb begin
    nacc    = acc;
    ncnt    = cnt;
    pay     = '0;
    pn      = '0;
    ld_data = '0;
    ld_cnt  = '0;
    if (hit && kind == EV_COND) begin
      nacc = {acc[NBITS-2:0], taken};
      ncnt = cnt + 1'b1;
      if (ncnt == CNTW'(NBITS)) begin
        ld_data[7:0] = OUTC_MARK | (8'(1) << NBITS) | 8'(nacc);
        ld_cnt       = CW'(1);
        nacc         = '0;
        ncnt         = '0;
      end
    end else begin
      nacc = '0;
      ncnt = '0;
      if (hit && kind == EV_IND) begin
        pay[7:0]       = HDR_IND;
        pay[8 +: IA_W] = dst;
        pn             = CW'(1 + IA_W / 8);
      end else if (hit && kind == EV_INT) begin
        pay[7:0]              = HDR_INT;
        pay[8 +: IA_W]        = src;
        pay[8 + IA_W +: IA_W] = dst;
        pn                    = CW'(1 + 2 * (IA_W / 8));
      end
      ld_data = have ? {pay, flush} : {8'h00, pay};
      ld_cnt  = pn + CW'(have);
    end
  end

  assign ld = take && (ld_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= nacc;
      cnt <= ncnt;
    end
  end

  // R2
  pend_lim_chk: assert property (@(posedge clk) disable iff (rst)
    cnt < CNTW'(NBITS));
  // R3
  flush_clr_chk: assert property (@(posedge clk) disable iff (rst)
    take && kind != EV_COND |=> cnt == '0);
endmodule

// File: rtl/bt_byteq.sv
module bt_byteq #(
  parameter int MAXB = 18,
  parameter int CW   = $clog2(MAXB + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [MAXB*8-1:0] ld_data,
  input  logic [CW-1:0]     ld_cnt,
  input  logic              pop,
  output logic              empty,
  output logic [7:0]        head
);
  logic [MAXB*8-1:0] q;
  logic [CW-1:0]     qcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '0;
      qcnt <= '0;
    end else if (ld) begin
      q    <= ld_data;
      qcnt <= ld_cnt;
    end else if (pop) begin
      q    <= q >> 8;
      qcnt <= qcnt - 1'b1;
    end
  end

  assign empty = (qcnt == '0);
  assign head  = q[7:0];

  // R7
  load_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ld |-> qcnt == '0);
  // R7
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> qcnt != '0);
endmodule

// File: rtl/bt_span.sv
module bt_span #(
  parameter int OA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OA_W-1:0] base,
  input  logic [OA_W-1:0] last,
  input  logic            ring,
  input  logic            fire,
  output logic [OA_W-1:0] ptr,
  output logic            full
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= base;
      full <= 1'b0;
    end else if (fire) begin
      if (ptr == last) begin
        if (ring) ptr  <= base;
        else      full <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    fire && ring && ptr == last |=> ptr == $past(base));
  // R8
  in_range_chk: assert property (@(posedge clk) disable iff (rst)
    ptr >= base && ptr <= last);
  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full |=> full && $stable(ptr));
  // R9
  no_write_full_chk: assert property (@(posedge clk) disable iff (rst)
    full |-> !fire);
endmodule

// File: rtl/bt_trace_enc.sv
module bt_trace_enc
  import bt_pkg::*;
#(
  parameter int IA_W   = 64,
  parameter int ROOT_W = 48,
  parameter int OA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [1:0]        ev_kind,
  input  logic              ev_taken,
  input  logic [IA_W-1:0]   ev_src,
  input  logic [IA_W-1:0]   ev_dst,
  input  logic [ROOT_W-1:0] ev_root,
  input  logic              cfg_filter_en,
  input  logic [ROOT_W-1:0] cfg_root_match,
  input  logic              cfg_ring,
  input  logic [OA_W-1:0]   cfg_base,
  input  logic [OA_W-1:0]   cfg_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OA_W-1:0]   out_addr,
  output logic [7:0]        out_byte,
  output logic              trace_full
);
  localparam int MAXB = 2 + 2 * (IA_W / 8);
  localparam int CW   = $clog2(MAXB + 1);

  logic              take, ld, q_empty, pop;
  logic [MAXB*8-1:0] ld_data;
  logic [CW-1:0]     ld_cnt;

  assign ev_ready  = q_empty && !trace_full;
  assign take      = ev_valid && ev_ready;
  assign out_valid = !q_empty && !trace_full;
  assign pop       = out_valid && out_ready;

  bt_pack #(.IA_W(IA_W), .ROOT_W(ROOT_W), .MAXB(MAXB), .CW(CW)) u_pack (
    .clk(clk), .rst(rst), .take(take), .kind(ev_kind), .taken(ev_taken),
    .src(ev_src), .dst(ev_dst), .root(ev_root), .filt_en(cfg_filter_en),
    .match(cfg_root_match), .ld(ld), .ld_data(ld_data), .ld_cnt(ld_cnt)
  );

  bt_byteq #(.MAXB(MAXB), .CW(CW)) u_q (
    .clk(clk), .rst(rst), .ld(ld), .ld_data(ld_data), .ld_cnt(ld_cnt),
    .pop(pop), .empty(q_empty), .head(out_byte)
  );

  bt_span #(.OA_W(OA_W)) u_span (
    .clk(clk), .rst(rst), .base(cfg_base), .last(cfg_last), .ring(cfg_ring),
    .fire(pop), .ptr(out_addr), .full(trace_full)
  );

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_addr));
  // R9
  stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    trace_full |=> !out_valid && !ev_ready);
endmodule

// File: tb/sim_bt_trace_enc.sv
module sim_bt_trace_enc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        ev_valid = 1'b0, ev_taken = 1'b0;
  logic [1:0]  ev_kind = 2'd0;
  logic [63:0] ev_src = '0, ev_dst = '0;
  logic [47:0] ev_root = '0;
  logic        cfg_filter_en = 1'b0, cfg_ring = 1'b1, out_ready = 1'b1;
  logic [47:0] cfg_root_match = '0;
  logic [15:0] cfg_base = 16'h0100, cfg_last = 16'h01FF;
  logic        ev_ready, out_valid, trace_full;
  logic [15:0] out_addr;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0, cap_n = 0, exp_n = 0;
  logic [7:0]  cap_b [0:63];
  logic [15:0] cap_a [0:63];
  logic [7:0]  exp_b [0:63];

  always #(CLK_PERIOD / 2) clk = ~clk;

  bt_trace_enc u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_kind(ev_kind), .ev_taken(ev_taken), .ev_src(ev_src), .ev_dst(ev_dst),
    .ev_root(ev_root), .cfg_filter_en(cfg_filter_en),
    .cfg_root_match(cfg_root_match), .cfg_ring(cfg_ring),
    .cfg_base(cfg_base), .cfg_last(cfg_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr), .out_byte(out_byte),
    .trace_full(trace_full)
  );

  always @(negedge clk) begin
    #(CLK_PERIOD / 4);
    if (!rst && out_valid && out_ready && cap_n < 64) begin
      cap_b[cap_n] = out_byte;
      cap_a[cap_n] = out_addr;
      cap_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ring, input logic [15:0] b, input logic [15:0] l);
    @(negedge clk);
    rst = 1'b1; cfg_ring = ring; cfg_base = b; cfg_last = l;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cap_n = 0;
  endtask

  task automatic send(input logic [1:0] k, input logic t, input logic [63:0] s,
                      input logic [63:0] d, input logic [47:0] r);
    @(negedge clk);
    ev_kind = k; ev_taken = t; ev_src = s; ev_dst = d; ev_root = r;
    ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ev_ready && !trace_full) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_seq(input string tag);
    chk(cap_n == exp_n, {tag, " count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap_b[i] == exp_b[i], tag, cap_b[i], exp_b[i]);
  endtask

  task automatic load_ind(input int at, input logic [63:0] d);
    exp_b[at] = 8'h01;
    for (int i = 0; i < 8; i++) exp_b[at + 1 + i] = d[8*i +: 8];
  endtask

  // R1
  task automatic t_reset();
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(ev_ready == 1'b1, "R1 ev_ready", ev_ready, 1);
    chk(trace_full == 1'b0, "R1 trace_full", trace_full, 0);
    chk(out_addr == cfg_base, "R1 out_addr", out_addr, cfg_base);
  endtask

  // R2: pattern 1,0,1,1,0,0 -> 0xC0 | 0x2C
  task automatic t_cond6();
    logic [5:0] pat = 6'b101100;
    cap_n = 0;
    for (int i = 0; i < 5; i++) send(2'd0, pat[5 - i], '0, '0, '0);
    repeat (2) @(negedge clk);
    chk(cap_n == 0, "R2 no early byte", cap_n, 0);
    send(2'd0, pat[0], '0, '0, '0);
    wait_idle();
    exp_n = 1; exp_b[0] = 8'hEC;
    chk_seq("R2");
  endtask

  // R3, R4: bits 1,1,0 then indirect
  task automatic t_flush_ind();
    logic [63:0] d = 64'h1122334455667788;
    cap_n = 0;
    send(2'd0, 1'b1, '0, '0, '0);
    send(2'd0, 1'b1, '0, '0, '0);
    send(2'd0, 1'b0, '0, '0, '0);
    send(2'd1, 1'b0, '0, d, '0);
    wait_idle();
    exp_n = 10; exp_b[0] = 8'h8E;
    load_ind(1, d);
    chk_seq("R3 R4");
  endtask

  // R5
  task automatic t_intr();
    logic [63:0] s = 64'h0706050403020100, d = 64'hF7F6F5F4F3F2F1F0;
    cap_n = 0;
    send(2'd2, 1'b0, s, d, '0);
    wait_idle();
    exp_n = 17; exp_b[0] = 8'h02;
    for (int i = 0; i < 8; i++) begin
      exp_b[1 + i] = s[8*i +: 8];
      exp_b[9 + i] = d[8*i +: 8];
    end
    chk_seq("R5");
  endtask

  // R6
  task automatic t_filter();
    logic [63:0] d = 64'h0123456789ABCDEF;
    cfg_filter_en = 1'b1; cfg_root_match = 48'h5;
    cap_n = 0;
    send(2'd0, 1'b1, '0, '0, 48'h5);
    send(2'd0, 1'b0, '0, '0, 48'h5);
    send(2'd0, 1'b1, '0, '0, 48'h9);
    wait_idle();
    exp_n = 1; exp_b[0] = 8'h86;
    chk_seq("R6 flush on mismatch");
    cap_n = 0;
    send(2'd1, 1'b0, '0, d, 48'h9);
    send(2'd0, 1'b1, '0, '0, 48'h9);
    repeat (4) @(negedge clk);
    chk(cap_n == 0, "R6 mismatch silent", cap_n, 0);
    chk(out_valid == 1'b0, "R6 no pending", out_valid, 0);
    cfg_filter_en = 1'b0;
    send(2'd1, 1'b0, '0, d, 48'h9);
    wait_idle();
    exp_n = 9; load_ind(0, d);
    chk_seq("R6 filter off");
  endtask

  // R7
  task automatic t_hold();
    logic [63:0] d = 64'hCAFE0000BEEF1234;
    logic [15:0] a;
    cap_n = 0;
    out_ready = 1'b0;
    send(2'd1, 1'b0, '0, d, '0);
    chk(out_valid == 1'b1, "R7 valid", out_valid, 1);
    chk(out_byte == 8'h01, "R7 head", out_byte, 8'h01);
    chk(ev_ready == 1'b0, "R7 ev_ready low", ev_ready, 0);
    a = out_addr;
    repeat (3) @(negedge clk);
    chk(out_byte == 8'h01 && out_valid, "R7 byte held", out_byte, 8'h01);
    chk(out_addr == a, "R7 addr held", out_addr, a);
    out_ready = 1'b1;
    wait_idle();
    exp_n = 9; load_ind(0, d);
    chk_seq("R7");
  endtask

  // R8
  task automatic t_ring();
    logic [63:0] d = 64'hA5A5A5A55A5A5A5A;
    do_reset(1'b1, 16'h0020, 16'h0023);
    send(2'd1, 1'b0, '0, d, '0);
    wait_idle();
    exp_n = 9; load_ind(0, d);
    chk_seq("R8 data");
    for (int i = 0; i < 9; i++)
      chk(cap_a[i] == 16'(16'h0020 + (i % 4)), "R8 addr", cap_a[i], 16'h0020 + (i % 4));
  endtask

  // R9
  task automatic t_stop();
    logic [63:0] d = 64'h1122334455667788;
    do_reset(1'b0, 16'h0040, 16'h0044);
    send(2'd1, 1'b0, '0, d, '0);
    repeat (15) @(negedge clk);
    exp_n = 5; load_ind(0, d);
    chk_seq("R9");
    for (int i = 0; i < 5 && i < cap_n; i++)
      chk(cap_a[i] == 16'(16'h0040 + i), "R9 addr", cap_a[i], 16'h0040 + i);
    chk(trace_full == 1'b1, "R9 full", trace_full, 1);
    chk(out_valid == 1'b0, "R9 out_valid", out_valid, 0);
    chk(ev_ready == 1'b0, "R9 ev_ready", ev_ready, 0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    do_reset(1'b1, 16'h0100, 16'h01FF);
    t_reset();
    t_cond6();
    t_flush_ind();
    t_intr();
    t_filter();
    t_hold();
    t_ring();
    t_stop();
    finish_run();
  end
endmodule